// File: doc/BRIEF.md
# SPI Transaction Header Stager

This block holds a short header, one to four bytes long, that must go out at the very start of an SPI transaction ahead of the ordinary transmit data. Software loads the header through one of four write strobes, each of which takes a different number of bytes from a shared data word. The header is locked in (committed) when the chip select is first seen going active while the header is enabled. From then on the block offers the staged bytes, lowest byte first, to the downstream serializer, which takes one byte per word slot.

Two gating modes control how header writes interact with an active select. In blocking mode a header write made while the select is active low is refused, and software has to turn the header on itself. In non-blocking mode a header write is accepted while the select is low, provided no header is already committed, and each accepted write turns the header on. In both modes a write made after commit is refused. Every refused write sets a sticky ignored flag. Software can clear the committed and ignored flags only by writing 0 to them.

Top module: `spi_hdr_stager`

## Requirements
- R1: After reset, the status word `ctl_status_o` reads 0 and `hdr_valid_o` is low. The status bits are: bit0 enable, bit1 committed, bit2 ignored, bit3 blocking mode.
- R2: Strobe bit k of `hdr_wr_i` (k = 0..3) stages k+1 bytes, taken from the low bytes of `hdr_wdata_i`. If several strobe bits are set, the highest one decides the length.
- R3: In blocking mode, a header write made while `cs_n_i` is sampled low is refused. The ignored flag sets, and the staged bytes and the enable bit are left unchanged.
- R4: In either mode, a header write made while the committed flag is set is refused, and the ignored flag sets.
- R5: In non-blocking mode, an accepted header write sets the enable bit. This includes a write made while `cs_n_i` is low, as long as no header is committed.
- R6: In blocking mode, an accepted header write leaves the enable bit as it was.
- R7: The committed flag sets on the clock edge where `cs_n_i` is sampled low after it was sampled high in the previous cycle, provided the enable bit is set. It does not set when the enable bit is clear.
- R8: A control write (`ctl_wr_i`) loads the enable and blocking-mode bits. It clears the committed or ignored flag only where the written bit is 0. Writing 1 to those two flags has no effect. Hardware set events take priority over a control write in the same cycle.
- R9: While committed, enabled and bytes remain, `hdr_valid_o` is high and `hdr_byte_o` presents the staged bytes lowest first. Each cycle in which `hdr_take_i` is high advances to the next byte.
- R10: An accepted header write made before commit replaces the data and the byte count staged by any earlier write.
- R11: When the last staged byte is taken, the enable bit clears and `hdr_valid_o` drops. The committed flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_i | input | 1 | Chip select, active low |
| hdr_wr_i | input | 4 | Header write strobes; bit k stages k+1 bytes |
| hdr_wdata_i | input | 32 | Header write data, lowest byte sent first |
| ctl_wr_i | input | 1 | Control/status write strobe |
| ctl_wdata_i | input | 4 | Control write value (bit0 enable, bit1 committed, bit2 ignored, bit3 blocking) |
| ctl_status_o | output | 4 | Flag readback, same encoding as the control write |
| hdr_valid_o | output | 1 | A header byte is offered to the serializer |
| hdr_byte_o | output | 8 | Offered header byte |
| hdr_take_i | input | 1 | Serializer consumes the offered byte |

## Verification
Every flag is a register that can be read directly on `ctl_status_o`. A wrong enable, committed or ignored bit therefore appears on the port one clock after the write or select edge that caused it. A corrupted byte pointer or byte count shows up as a wrong value on `hdr_byte_o`, or as `hdr_valid_o` staying high or low for the wrong number of take cycles. It can be seen no earlier than the first word slot after commit. For that reason the bench compares every output in every cycle against a model built from the requirements, and it drives enough commits with headers of every length to cover the byte pointer.

// File: rtl/spi_hdr_pkg.sv
// Package: shared flag layout for the SPI header stager.
// Assumes the software-visible status word keeps the bit order below.
package spi_hdr_pkg;
    // Bit order of ctl_status_o / ctl_wdata_i: {blk, ign, cmt, en}
    typedef struct packed {
        logic blk;   // 1 = blocking gating mode
        logic ign;   // a header write was refused
        logic cmt;   // header committed to the current transaction
        logic en;    // header enabled
    } hdr_flags_t;

    localparam int FLAG_W = $bits(hdr_flags_t);
endpackage

// File: rtl/spi_hdr_wdec.sv
// Module: header write decoder.
// Turns the per-width write strobes into a single write flag and a byte
// count. Assumes software normally raises one strobe at a time; when several
// are set, the widest strobe decides the count.
module spi_hdr_wdec #(
    parameter int MAX_BYTES = 4,
    parameter int CNT_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic [MAX_BYTES-1:0] hdr_wr_i,
    output logic                 any_wr_o,
    output logic [CNT_W-1:0]     len_o
);
    // Scan the strobes from narrow to wide so the widest set strobe wins.
    always_comb begin
        any_wr_o = 1'b0;
        len_o    = '0;
        for (int k = 0; k < MAX_BYTES; k++) begin
            if (hdr_wr_i[k]) begin
                any_wr_o = 1'b1;
                len_o    = CNT_W'(k + 1);
            end
        end
    end
endmodule

// File: rtl/spi_hdr_store.sv
// Module: header byte store and read pointer.
// Holds the staged header word, the number of bytes still to send, and the
// index of the next byte. Assumes accept and pop are never high together
// (accept needs an uncommitted header, pop needs a committed one).
module spi_hdr_store #(
    parameter int BYTE_W    = 8,
    parameter int MAX_BYTES = 4,
    parameter int CNT_W     = $clog2(MAX_BYTES + 1),
    parameter int IDX_W     = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1,
    parameter int DATA_W    = BYTE_W * MAX_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic [CNT_W-1:0]  len_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] staged_o,
    output logic [CNT_W-1:0]  rem_o,
    output logic              last_o,
    output logic [BYTE_W-1:0] byte_o
);
    logic [IDX_W-1:0] idx_q;

    // Load a new header on an accepted write; step the pointer on each pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged_o <= '0;
            rem_o    <= '0;
            idx_q    <= '0;
        end else if (accept_i) begin
            staged_o <= wdata_i;
            rem_o    <= len_i;
            idx_q    <= '0;
        end else if (pop_i) begin
            rem_o    <= rem_o - CNT_W'(1);
            idx_q    <= idx_q + IDX_W'(1);
        end
    end

    // Present the byte under the pointer; flag the final one.
    always_comb begin
        byte_o = staged_o[idx_q*BYTE_W +: BYTE_W];
        last_o = (rem_o == CNT_W'(1));
    end
endmodule

// File: rtl/spi_hdr_flags.sv
// Module: header gating and status flags.
// Decides whether a header write is accepted or refused, detects the
// chip-select falling edge for commit, and keeps the software flags.
// Assumes cs_n_i is already synchronous to clk.
module spi_hdr_flags
    import spi_hdr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              any_wr_i,
    input  logic              pop_i,
    input  logic              last_i,
    input  logic              sw_wr_i,
    input  logic [FLAG_W-1:0] sw_wdata_i,
    output hdr_flags_t        flags_o,
    output logic              accept_o
);
    hdr_flags_t sw_val, flags_nx;
    logic       cs_q, reject, commit;

    // Keep the previous chip-select sample and the flag state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q    <= 1'b1;
            flags_o <= '0;
        end else begin
            cs_q    <= cs_n_i;
            flags_o <= flags_nx;
        end
    end

    // Apply software writes first, then let hardware events override them.
    always_comb begin
        sw_val   = hdr_flags_t'(sw_wdata_i);
        reject   = any_wr_i & (flags_o.cmt | (flags_o.blk & ~cs_n_i));
        accept_o = any_wr_i & ~reject;
        commit   = flags_o.en & cs_q & ~cs_n_i;
        flags_nx = flags_o;
        if (sw_wr_i) begin
            flags_nx.en  = sw_val.en;
            flags_nx.blk = sw_val.blk;
            if (!sw_val.cmt) flags_nx.cmt = 1'b0;
            if (!sw_val.ign) flags_nx.ign = 1'b0;
        end
        if (accept_o && !flags_o.blk) flags_nx.en  = 1'b1;
        if (pop_i && last_i)          flags_nx.en  = 1'b0;
        if (commit)                   flags_nx.cmt = 1'b1;
        if (reject)                   flags_nx.ign = 1'b1;
    end
endmodule

// File: rtl/spi_hdr_stager.sv
// Module: SPI transaction header stager (top).
// Stages a 1..MAX_BYTES byte header, commits it on the chip-select falling
// edge, and offers its bytes lowest first to the serializer ahead of the
// normal transmit data. Assumes the serializer raises hdr_take_i only while
// hdr_valid_o is high; a take at any other time is ignored.
module spi_hdr_stager
    import spi_hdr_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int MAX_BYTES = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cs_n_i,
    input  logic [MAX_BYTES-1:0]        hdr_wr_i,
    input  logic [BYTE_W*MAX_BYTES-1:0] hdr_wdata_i,
    input  logic                        ctl_wr_i,
    input  logic [FLAG_W-1:0]           ctl_wdata_i,
    output logic [FLAG_W-1:0]           ctl_status_o,
    output logic                        hdr_valid_o,
    output logic [BYTE_W-1:0]           hdr_byte_o,
    input  logic                        hdr_take_i
);
    localparam int CNT_W  = $clog2(MAX_BYTES + 1);
    localparam int DATA_W = BYTE_W * MAX_BYTES;

    hdr_flags_t        flags;
    logic              any_wr, accept, pop, last;
    logic [CNT_W-1:0]  wr_len, rem;
    logic [DATA_W-1:0] staged;

    spi_hdr_wdec #(.MAX_BYTES(MAX_BYTES)) u_wdec (
        .hdr_wr_i (hdr_wr_i),
        .any_wr_o (any_wr),
        .len_o    (wr_len)
    );

    spi_hdr_store #(.BYTE_W(BYTE_W), .MAX_BYTES(MAX_BYTES)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept),
        .len_i    (wr_len),
        .wdata_i  (hdr_wdata_i),
        .pop_i    (pop),
        .staged_o (staged),
        .rem_o    (rem),
        .last_o   (last),
        .byte_o   (hdr_byte_o)
    );

    spi_hdr_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_i     (cs_n_i),
        .any_wr_i   (any_wr),
        .pop_i      (pop),
        .last_i     (last),
        .sw_wr_i    (ctl_wr_i),
        .sw_wdata_i (ctl_wdata_i),
        .flags_o    (flags),
        .accept_o   (accept)
    );

    // Offer a byte only for a committed, enabled header with bytes left.
    always_comb begin
        hdr_valid_o  = flags.cmt & flags.en & (rem != '0);
        pop          = hdr_valid_o & hdr_take_i;
        ctl_status_o = flags;
    end
endmodule

// File: rtl/spi_hdr_stager_chk.sv
// Module: property checker for spi_hdr_stager, attached by bind.
// Assumes the status word layout {blk, ign, cmt, en}.
module spi_hdr_stager_chk #(
    parameter int BYTE_W    = 8,
    parameter int MAX_BYTES = 4,
    parameter int CNT_W     = $clog2(MAX_BYTES + 1)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        cs_n_i,
    input logic [MAX_BYTES-1:0]        hdr_wr_i,
    input logic                        ctl_wr_i,
    input logic [3:0]                  ctl_wdata_i,
    input logic [3:0]                  ctl_status_o,
    input logic                        hdr_valid_o,
    input logic                        hdr_take_i,
    input logic [CNT_W-1:0]            rem,
    input logic [BYTE_W*MAX_BYTES-1:0] staged
);
    assert_valid_needs_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid_o |-> (ctl_status_o[1] && ctl_status_o[0]));

    assert_ignore_has_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_status_o[2]) |-> $past(|hdr_wr_i));

    assert_commit_needs_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_status_o[1]) |-> $past(!cs_n_i && ctl_status_o[0]));

    assert_commit_clear_by_sw_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_status_o[1]) |-> $past(ctl_wr_i && !ctl_wdata_i[1]));

    assert_blocked_write_keeps_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((|hdr_wr_i) && ctl_status_o[3] && !cs_n_i) |=> $stable(staged));

    assert_last_byte_drops_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid_o && hdr_take_i && rem == CNT_W'(1)) |=> !ctl_status_o[0]);

    assert_count_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rem <= CNT_W'(MAX_BYTES));
endmodule

bind spi_hdr_stager spi_hdr_stager_chk #(.BYTE_W(BYTE_W), .MAX_BYTES(MAX_BYTES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n_i       (cs_n_i),
    .hdr_wr_i     (hdr_wr_i),
    .ctl_wr_i     (ctl_wr_i),
    .ctl_wdata_i  (ctl_wdata_i),
    .ctl_status_o (ctl_status_o),
    .hdr_valid_o  (hdr_valid_o),
    .hdr_take_i   (hdr_take_i),
    .rem          (rem),
    .staged       (staged)
);

// File: tb/spi_hdr_stager_bench.sv
// Bench: compares every cycle against a model built from the requirements,
// using directed corner cases followed by seeded random stimulus.
module spi_hdr_stager_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic [3:0]  hdr_wr = '0;
    logic [31:0] hdr_wdata = '0;
    logic        ctl_wr = 1'b0;
    logic [3:0]  ctl_wdata = '0;
    logic        take = 1'b0;
    logic [3:0]  status;
    logic        valid;
    logic [7:0]  hbyte;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Model state, taken from the requirements
    logic        m_en, m_cmt, m_ign, m_blk, m_csq;
    logic [31:0] m_data;
    int          m_rem, m_idx;

    always #10 clk = ~clk;   // 50 MHz

    spi_hdr_stager u_spi_hdr_stager (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .hdr_wr_i(hdr_wr),
        .hdr_wdata_i(hdr_wdata), .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wdata),
        .ctl_status_o(status), .hdr_valid_o(valid), .hdr_byte_o(hbyte),
        .hdr_take_i(take)
    );

    // R2: the widest set strobe decides the byte count
    function automatic int strobe_len(input logic [3:0] s);
        int n = 0;
        for (int k = 0; k < 4; k++) if (s[k]) n = k + 1;
        return n;
    endfunction

    function automatic logic m_valid();
        return m_cmt && m_en && (m_rem != 0);
    endfunction

    function automatic logic [7:0] m_byte();
        return m_data[m_idx*8 +: 8];
    endfunction

    // Model update at each clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_cmt = 0; m_ign = 0; m_blk = 0; m_csq = 1;
            m_data = '0; m_rem = 0; m_idx = 0;
        end else begin
            logic wr_any, rej, acc, cmt_ev, pop, lst;
            logic blk_now, en_now;
            wr_any  = |hdr_wr;
            rej     = wr_any && (m_cmt || (m_blk && !cs_n));
            acc     = wr_any && !rej;
            cmt_ev  = m_en && m_csq && !cs_n;
            pop     = m_valid() && take;
            lst     = (m_rem == 1);
            blk_now = m_blk;
            en_now  = m_en;
            if (ctl_wr) begin
                en_now = ctl_wdata[0];
                m_blk  = ctl_wdata[3];
                if (!ctl_wdata[1]) m_cmt = 0;
                if (!ctl_wdata[2]) m_ign = 0;
            end
            if (acc && !blk_now) en_now = 1;
            if (pop && lst) en_now = 0;
            if (cmt_ev) m_cmt = 1;
            if (rej) m_ign = 1;
            m_en = en_now;
            if (acc) begin
                m_data = hdr_wdata; m_rem = strobe_len(hdr_wr); m_idx = 0;
            end else if (pop) begin
                m_rem = m_rem - 1; m_idx = m_idx + 1;
            end
            m_csq = cs_n;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compare all outputs against the model
    task automatic compare_all();
        chk("R5 enable bit", 32'(status[0]), 32'(m_en));
        chk("R7 committed bit", 32'(status[1]), 32'(m_cmt));
        chk("R3 ignored bit", 32'(status[2]), 32'(m_ign));
        chk("R8 mode bit", 32'(status[3]), 32'(m_blk));
        chk("R9 valid", 32'(valid), 32'(m_valid()));
        if (m_valid()) chk("R9 byte", 32'(hbyte), 32'(m_byte()));
    endtask

    // Drive one cycle of inputs at the falling edge, compare at the next one
    task automatic step(input logic cs, input logic [3:0] wr, input logic [31:0] wd,
                        input logic tk, input logic sw, input logic [3:0] swd);
        cs_n = cs; hdr_wr = wr; hdr_wdata = wd; take = tk;
        ctl_wr = sw; ctl_wdata = swd;
        @(posedge clk);
        @(negedge clk);
        cs_n = cs; hdr_wr = '0; take = 1'b0; ctl_wr = 1'b0;
        compare_all();
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R1 reset status", 32'(status), 32'h0);
        chk("R1 reset valid", 32'(valid), 32'h0);

        // R10 replace before commit, R2 two-byte strobe, R9 low byte first
        step(1, 4'b1000, 32'h44332211, 0, 0, 4'h0);
        step(1, 4'b0010, 32'hDDCCBBAA, 0, 0, 4'h0);
        step(0, 4'b0000, 32'h0, 0, 0, 4'h0);
        chk("R2 first byte", 32'(hbyte), 32'hAA);
        step(0, 4'b0000, 32'h0, 1, 0, 4'h0);
        chk("R10 second byte", 32'(hbyte), 32'hBB);
        step(0, 4'b0000, 32'h0, 1, 0, 4'h0);
        chk("R11 enable cleared, committed kept", 32'(status), 32'h2);
        chk("R10 count replaced", 32'(valid), 32'h0);

        // R4 write while committed
        step(0, 4'b0001, 32'h77, 0, 0, 4'h0);
        chk("R4 ignored after commit", 32'(status), 32'h6);

        // R8 control write: blocking, enable, clear both flags
        step(0, 4'b0000, 32'h0, 0, 1, 4'b1001);
        chk("R8 control write", 32'(status), 32'h9);

        // R3 blocked write while select low
        step(0, 4'b0100, 32'h00CAFE00, 0, 0, 4'h0);
        chk("R3 blocked write flagged", 32'(status), 32'hD);
        chk("R3 no offer", 32'(valid), 32'h0);

        // R6 blocking-mode write keeps enable clear
        step(1, 4'b0000, 32'h0, 0, 1, 4'b1000);
        step(1, 4'b0001, 32'h0000005A, 0, 0, 4'h0);
        chk("R6 enable unchanged", 32'(status), 32'h8);
        step(1, 4'b0000, 32'h0, 0, 1, 4'b1001);
        step(0, 4'b0000, 32'h0, 0, 0, 4'h0);
        chk("R9 blocking header byte", 32'(hbyte), 32'h5A);
        step(0, 4'b0000, 32'h0, 1, 0, 4'h0);
        chk("R11 single byte done", 32'(status), 32'hA);

        // R7 no commit while disabled
        step(1, 4'b0000, 32'h0, 0, 1, 4'b0000);
        step(0, 4'b0000, 32'h0, 0, 0, 4'h0);
        chk("R7 no commit without enable", 32'(status), 32'h0);

        // Seeded random traffic
        for (int i = 0; i < 4000; i++) begin
            logic        rcs, rtk, rsw;
            logic [3:0]  rwr, rswd;
            rcs  = (($urandom % 8) == 0) ? ~cs_n : cs_n;
            rwr  = (($urandom % 6) == 0) ? 4'($urandom) : 4'b0000;
            rtk  = 1'($urandom);
            rsw  = (($urandom % 20) == 0);
            rswd = 4'($urandom);
            step(rcs, rwr, $urandom, rtk, rsw, rswd);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule